// File: doc/BRIEF.md
# Byte-Aliased General Register File

This block holds four 32-bit general-purpose registers. Each register can be read or written through four overlapping views: the whole 32-bit word, its low 16-bit half, the low byte of that half, and the high byte of that half. The narrow views are not separate registers. They are windows onto one storage word, so a write through any view changes only the bytes that view covers.

A single write port takes a register index, a view select and data. The write commits on the rising clock edge. Two independent combinational read ports each take a register index and a view select, and return that view zero-extended to 32 bits. An asynchronous active-low reset clears every register.

Top module: `grf_alias_file`

## Requirements
- R1: While reset is asserted, and after it is released until the first write, every view of every register reads as zero on both ports.
- R2: The view select is encoded as 00 = bits 7:0, 01 = bits 15:8, 10 = bits 15:0, 11 = bits 31:0. A read returns the selected field right-aligned, with all bits above it zero.
- R3: A write with view 00 puts wr_data[7:0] into bits 7:0 of the register and leaves bits 31:8 unchanged.
- R4: A write with view 01 puts wr_data[7:0] into bits 15:8 of the register and leaves bits 31:16 and 7:0 unchanged.
- R5: A write with view 10 puts wr_data[15:0] into bits 15:0, so both byte views change together, and leaves bits 31:16 unchanged.
- R6: A write with view 11 replaces all 32 bits of the register with wr_data.
- R7: A write changes only the register named by wr_idx. When wr_en is low, no register changes.
- R8: A read of the register being written in the same cycle returns the value from before the write. The new value is visible from the cycle after the clock edge.
- R9: The two read ports are independent. Each returns its own index and view, and both return the same value when given the same index and view.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all registers |
| wr_en | input | 1 | Write request for this cycle |
| wr_idx | input | 2 | Register index to write |
| wr_view | input | 2 | View select for the write (encoding in R2) |
| wr_data | input | 32 | Write data, right-aligned for narrow views |
| ra_idx | input | 2 | Register index for read port A |
| ra_view | input | 2 | View select for read port A |
| ra_data | output | 32 | Read port A result, zero-extended |
| rb_idx | input | 2 | Register index for read port B |
| rb_view | input | 2 | View select for read port B |
| rb_data | output | 32 | Read port B result, zero-extended |

## Verification
The properties assume that wr_en is held low while reset is asserted. Under that assumption, nothing logged before reset is taken as a committed write. The bench drives no write until it has released reset on a falling edge. The lane-preservation properties fire only when port A keeps the same index and the full-word view across two cycles. The stimulus includes such back-to-back pairs for each view, and also runs a long pseudo-random phase in which port A often revisits the register last written.

// File: rtl/grf_pkg.sv
package grf_pkg;

  localparam int unsigned LANES = 4;

  typedef enum logic [1:0] {
    VIEW_LO8 = 2'b00,
    VIEW_HI8 = 2'b01,
    VIEW_W16 = 2'b10,
    VIEW_W32 = 2'b11
  } view_e;

endpackage

// File: rtl/grf_lane_mask.sv
module grf_lane_mask
  import grf_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input  view_e             view,
  input  logic [WORD_W-1:0] din,
  output logic [LANES-1:0]  lane_en,
  output logic [WORD_W-1:0] lane_data
);

  // Byte-lane enables per view, and data steered into the lanes.
  always_comb begin
    lane_en   = '0;
    lane_data = din;
    unique case (view)
      VIEW_LO8: lane_en = 4'b0001;
      VIEW_HI8: begin
        lane_en                     = 4'b0010;
        lane_data[2*LANE_W-1:LANE_W] = din[LANE_W-1:0];
      end
      VIEW_W16: lane_en = 4'b0011;
      VIEW_W32: lane_en = 4'b1111;
      default:  lane_en = '0;
    endcase
  end

endmodule

// File: rtl/grf_word.sv
module grf_word
  import grf_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [LANES-1:0]  lane_en,
  input  logic [WORD_W-1:0] lane_data,
  output logic [WORD_W-1:0] q
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic              ce;
    logic [LANE_W-1:0] d_nxt;
    logic [LANE_W-1:0] q_r;

    always_comb begin
      ce    = sel & lane_en[l];
      d_nxt = lane_data[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_r <= '0;
      end else if (ce) begin
        q_r <= d_nxt;
      end
    end

    assign q[l*LANE_W +: LANE_W] = q_r;
  end

endmodule

// File: rtl/grf_read_view.sv
module grf_read_view
  import grf_pkg::*;
#(
  parameter int unsigned LANE_W = 8,
  localparam int unsigned WORD_W = LANES * LANE_W
) (
  input  logic [WORD_W-1:0] word,
  input  view_e             view,
  output logic [WORD_W-1:0] rdata
);

  always_comb begin
    rdata = '0;
    unique case (view)
      VIEW_LO8: rdata[LANE_W-1:0]   = word[LANE_W-1:0];
      VIEW_HI8: rdata[LANE_W-1:0]   = word[2*LANE_W-1:LANE_W];
      VIEW_W16: rdata[2*LANE_W-1:0] = word[2*LANE_W-1:0];
      VIEW_W32: rdata               = word;
      default:  rdata               = '0;
    endcase
  end

endmodule

// File: rtl/grf_alias_file.sv
module grf_alias_file
  import grf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned LANE_W   = 8,
  localparam int unsigned WORD_W  = LANES * LANE_W,
  localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_view,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [1:0]        ra_view,
  output logic [WORD_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  input  logic [1:0]        rb_view,
  output logic [WORD_W-1:0] rb_data
);

  logic [LANES-1:0]  lane_en;
  logic [WORD_W-1:0] lane_data;
  logic [WORD_W-1:0] words [NUM_REGS];
  logic [WORD_W-1:0] ra_word;
  logic [WORD_W-1:0] rb_word;

  grf_lane_mask #(.LANE_W(LANE_W)) u_mask (
    .view      (view_e'(wr_view)),
    .din       (wr_data),
    .lane_en   (lane_en),
    .lane_data (lane_data)
  );

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(r));

    grf_word #(.LANE_W(LANE_W)) u_word (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .lane_en   (lane_en),
      .lane_data (lane_data),
      .q         (words[r])
    );
  end

  always_comb begin
    ra_word = words[ra_idx];
    rb_word = words[rb_idx];
  end

  grf_read_view #(.LANE_W(LANE_W)) u_view_a (
    .word  (ra_word),
    .view  (view_e'(ra_view)),
    .rdata (ra_data)
  );

  grf_read_view #(.LANE_W(LANE_W)) u_view_b (
    .word  (rb_word),
    .view  (view_e'(rb_view)),
    .rdata (rb_data)
  );

endmodule

// File: rtl/grf_alias_file_chk.sv
module grf_alias_file_chk
  import grf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned LANE_W   = 8,
  localparam int unsigned WORD_W  = LANES * LANE_W,
  localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [1:0]        wr_view,
  input logic [WORD_W-1:0] wr_data,
  input logic [IDX_W-1:0]  ra_idx,
  input logic [1:0]        ra_view,
  input logic [WORD_W-1:0] ra_data,
  input logic [IDX_W-1:0]  rb_idx,
  input logic [1:0]        rb_view,
  input logic [WORD_W-1:0] rb_data
);

  localparam int unsigned H = 2 * LANE_W;

  // One-cycle history, cleared by reset.
  logic              p_we;
  logic [IDX_W-1:0]  p_widx;
  logic [1:0]        p_wview;
  logic [WORD_W-1:0] p_wdata;
  logic [IDX_W-1:0]  p_aidx;
  logic [1:0]        p_aview;
  logic [WORD_W-1:0] p_adata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_we    <= 1'b0;
      p_widx  <= '0;
      p_wview <= '0;
      p_wdata <= '0;
      p_aidx  <= '0;
      p_aview <= '0;
      p_adata <= '0;
    end else begin
      p_we    <= wr_en;
      p_widx  <= wr_idx;
      p_wview <= wr_view;
      p_wdata <= wr_data;
      p_aidx  <= ra_idx;
      p_aview <= ra_view;
      p_adata <= ra_data;
    end
  end

  logic watch_a;
  assign watch_a = (ra_idx == p_aidx) && (ra_view == VIEW_W32) && (p_aview == VIEW_W32);

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ra_data == '0 && rb_data == '0));

  p_zext_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_view != VIEW_W32) |-> (ra_data[WORD_W-1:H] == '0));

  p_zext_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_view == VIEW_LO8 || rb_view == VIEW_HI8) |-> (rb_data[WORD_W-1:LANE_W] == '0));

  p_lo_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (watch_a && p_we && p_widx == ra_idx && p_wview == VIEW_LO8) |->
      (ra_data[WORD_W-1:LANE_W] == p_adata[WORD_W-1:LANE_W] &&
       ra_data[LANE_W-1:0] == p_wdata[LANE_W-1:0]));

  p_hi_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (watch_a && p_we && p_widx == ra_idx && p_wview == VIEW_HI8) |->
      (ra_data[WORD_W-1:H] == p_adata[WORD_W-1:H] &&
       ra_data[LANE_W-1:0] == p_adata[LANE_W-1:0] &&
       ra_data[H-1:LANE_W] == p_wdata[LANE_W-1:0]));

  p_half_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (watch_a && p_we && p_widx == ra_idx && p_wview == VIEW_W16) |->
      (ra_data[WORD_W-1:H] == p_adata[WORD_W-1:H] &&
       ra_data[H-1:0] == p_wdata[H-1:0]));

  p_full_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (watch_a && p_we && p_widx == ra_idx && p_wview == VIEW_W32) |->
      (ra_data == p_wdata));

  p_untouched_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (watch_a && (!p_we || p_widx != ra_idx)) |-> (ra_data == p_adata));

  p_ports_agree_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_idx == rb_idx && ra_view == rb_view) |-> (ra_data == rb_data));

endmodule

bind grf_alias_file grf_alias_file_chk #(
  .NUM_REGS (NUM_REGS),
  .LANE_W   (LANE_W)
) u_chk (.*);

// File: tb/grf_alias_file_bench.sv
module grf_alias_file_bench;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_idx;
  logic [1:0]  wr_view;
  logic [31:0] wr_data;
  logic [1:0]  ra_idx;
  logic [1:0]  ra_view;
  logic [31:0] ra_data;
  logic [1:0]  rb_idx;
  logic [1:0]  rb_view;
  logic [31:0] rb_data;

  grf_alias_file u_grf_alias_file (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view), .wr_data(wr_data),
    .ra_idx(ra_idx), .ra_view(ra_view), .ra_data(ra_data),
    .rb_idx(rb_idx), .rb_view(rb_view), .rb_data(rb_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  typedef struct {
    logic [31:0] exp_a;
    logic [31:0] exp_b;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  logic [31:0] mdl [4];
  int          n_cmp;
  int          n_bad;
  bit          done;

  function automatic logic [31:0] view_of(logic [31:0] w, logic [1:0] v);
    case (v)
      2'b00:   return {24'h0, w[7:0]};
      2'b01:   return {24'h0, w[15:8]};
      2'b10:   return {16'h0, w[15:0]};
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] merge(logic [31:0] w, logic [1:0] v, logic [31:0] d);
    case (v)
      2'b00:   return {w[31:8], d[7:0]};
      2'b01:   return {w[31:16], d[7:0], w[7:0]};
      2'b10:   return {w[31:16], d[15:0]};
      default: return d;
    endcase
  endfunction

  // Driver: apply one cycle of stimulus, queue the expected reads
  // (old contents), then commit the write into the model.
  task automatic op(input bit we, input logic [1:0] wi, input logic [1:0] wv,
                    input logic [31:0] wd, input logic [1:0] ai, input logic [1:0] av,
                    input logic [1:0] bi, input logic [1:0] bv, input string tag);
    item_t it;
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_view = wv; wr_data = wd;
    ra_idx = ai; ra_view = av; rb_idx = bi; rb_view = bv;
    it.exp_a = view_of(mdl[ai], av);
    it.exp_b = view_of(mdl[bi], bv);
    it.tag   = tag;
    sb_q.push_back(it);
    if (we) mdl[wi] = merge(mdl[wi], wv, wd);
  endtask

  task automatic rd(input logic [1:0] ai, input logic [1:0] av,
                    input logic [1:0] bi, input logic [1:0] bv, input string tag);
    op(1'b0, 2'd0, 2'd0, 32'hDEAD_BEEF, ai, av, bi, bv, tag);
  endtask

  // Monitor: mid low phase, compare outputs with queued items.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_cmp += 2;
        if (ra_data !== it.exp_a) begin
          n_bad++;
          $display("FAIL %s port A: actual %h expected %h", it.tag, ra_data, it.exp_a);
        end
        if (rb_data !== it.exp_b) begin
          n_bad++;
          $display("FAIL %s port B: actual %h expected %h", it.tag, rb_data, it.exp_b);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    n_cmp = 0; n_bad = 0; done = 1'b0;
    for (int r = 0; r < 4; r++) mdl[r] = '0;
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_view = '0; wr_data = '0;
    ra_idx = '0; ra_view = 2'b11; rb_idx = 2'd1; rb_view = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: all registers zero after reset
    for (int r = 0; r < 4; r++) rd(2'(r), 2'b11, 2'(r), 2'b00, "R1");

    // R6 / R8: full write, same-cycle read sees the old value
    op(1, 2'd0, 2'b11, 32'h1122_3344, 2'd0, 2'b11, 2'd0, 2'b10, "R8");
    rd(2'd0, 2'b11, 2'd0, 2'b01, "R6");
    // R3: low byte write
    op(1, 2'd0, 2'b00, 32'hFFFF_FFAA, 2'd0, 2'b11, 2'd1, 2'b11, "R8");
    rd(2'd0, 2'b11, 2'd0, 2'b00, "R3");
    // R4: high byte write
    op(1, 2'd0, 2'b01, 32'h0000_00BB, 2'd0, 2'b11, 2'd0, 2'b01, "R4");
    rd(2'd0, 2'b11, 2'd0, 2'b01, "R4");
    // R5: half write changes both bytes, keeps upper half
    op(1, 2'd0, 2'b10, 32'h7777_CDEF, 2'd0, 2'b11, 2'd0, 2'b10, "R5");
    rd(2'd0, 2'b11, 2'd0, 2'b00, "R5");
    // R2: each view of the same register
    rd(2'd0, 2'b00, 2'd0, 2'b01, "R2");
    rd(2'd0, 2'b10, 2'd0, 2'b11, "R2");
    // R7: other registers, then disabled write
    op(1, 2'd1, 2'b11, 32'hA5A5_5A5A, 2'd0, 2'b11, 2'd1, 2'b11, "R7");
    op(1, 2'd2, 2'b01, 32'h0000_0042, 2'd0, 2'b11, 2'd1, 2'b11, "R7");
    op(1, 2'd3, 2'b10, 32'h0000_9876, 2'd2, 2'b11, 2'd0, 2'b11, "R7");
    op(0, 2'd0, 2'b11, 32'h0BAD_F00D, 2'd3, 2'b11, 2'd0, 2'b11, "R7");
    rd(2'd0, 2'b11, 2'd2, 2'b01, "R7");
    // R9: independent ports
    rd(2'd1, 2'b01, 2'd3, 2'b10, "R9");
    rd(2'd3, 2'b00, 2'd1, 2'b11, "R9");

    // Pseudo-random mix; port A often follows the write target.
    seed = 32'h1357_9BDF;
    for (int i = 0; i < 400; i++) begin
      logic [1:0] wi;
      seed = seed * 32'd1664525 + 32'd1013904223;
      wi = seed[25:24];
      op(seed[31], wi, seed[29:28], {seed[15:0], seed[31:16]},
         seed[27] ? wi : seed[23:22], seed[26] ? 2'b11 : seed[21:20],
         seed[19:18], seed[17:16], "R9");
    end

    @(negedge clk);
    #8;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule